// File: doc/BRIEF.md
# CAN receive buffer router

This block sits behind the bit-level receiver of a CAN controller. When a complete frame has been received, it is handed to the router as a one-cycle strobe together with its 29-bit identifier field, its extended-frame flag and its validity verdict. The router compares the identifier against six acceptance filters. Filters 0 and 1 belong to receive buffer 0 and share one mask. Filters 2 to 5 belong to receive buffer 1 and share a second mask. The router then chooses the buffer that will store the frame. One clock later it issues a store strobe, a buffer select and the index of the filter that was hit, which together steer the message storage RAM.

Each buffer has a full flag. The flag is set when a frame is loaded into that buffer and is cleared by the host through a dedicated clear input. When buffer 0 is full, a frame aimed at it can roll over into buffer 1. A frame that finds no room sets a sticky per-buffer overflow flag and is dropped. An invalid frame causes an error-frame request instead of a store. A listen-only mode bypasses all filtering and accepts every frame, including invalid ones. Each buffer also drives an active-low full pin that is gated by a function bit and an enable bit.

Identifier layout: bits 28:18 hold the 11-bit base identifier and bits 17:0 hold the extension. A standard frame places its identifier in bits 28:18, and only those bits take part in its comparison.

Top module: `can_rx_router`

## Requirements
- R1: A frame presented with `msg_ok`=0 while `listen_only`=0 produces no store and raises `err_frame` for exactly one cycle, one clock after `msg_valid`.
- R2: A valid frame matching filter 0 or 1 while buffer 0 is not full is stored in buffer 0 (`store_sel`=0). `hit_flt` gives the lowest-numbered matching filter, and `full[0]` is set.
- R3: A frame matching a buffer-0 filter while buffer 0 is full and `rollover_en`=1 is stored in buffer 1 if buffer 1 is not full. `hit_flt` keeps the buffer-0 filter index.
- R4: A frame matching a buffer-0 filter while buffer 0 is full and `rollover_en`=0 is dropped and sets `ovf[0]`.
- R5: A frame that matches no buffer-0 filter but matches filter 2 to 5 goes to buffer 1, and `hit_flt` gives the lowest matching index from that group. If buffer 1 is full, the frame is dropped and `ovf[1]` is set. A frame that rolls over into a full buffer 1 also sets `ovf[1]`.
- R6: An identifier bit takes part in the comparison only where the group mask bit is 1. A filter also requires `msg_ext` to equal its bit in `flt_ext`.
- R7: For extended frames, identifier bits 17 and 16 are never compared. For standard frames, only bits 28:18 are compared.
- R8: With `listen_only`=1, every frame, valid or not, is treated as a buffer-0 hit with `hit_flt`=0, and `err_frame` stays low. The full, rollover and overflow rules still apply.
- R9: `full_n[b]` is low only while `full[b]`, `pin_func[b]` and `pin_en[b]` are all 1.
- R10: A pulse on `clr_full[b]` clears `full[b]` and releases `full_n[b]` high. A pulse on `clr_ovf[b]` clears `ovf[b]`. A store into a buffer in the same cycle as its clear leaves the flag set.
- R11: After reset, `full`, `ovf`, `store_stb` and `err_frame` are 0 and `full_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | One-cycle strobe: a received frame is presented |
| msg_ok | input | 1 | Frame passed all reception checks |
| msg_id | input | IW | Identifier, base in 28:18, extension in 17:0 |
| msg_ext | input | 1 | Extended-frame flag |
| listen_only | input | 1 | Accept every frame without filtering |
| rollover_en | input | 1 | Allow buffer 0 to spill into buffer 1 |
| mask0 | input | IW | Mask shared by the buffer-0 filters |
| mask1 | input | IW | Mask shared by the buffer-1 filters |
| flt_id | input | NF*IW | Filter identifiers, filter i at bits i*IW +: IW |
| flt_ext | input | NF | Extended-frame setting per filter |
| pin_func | input | 2 | Full-pin function select per buffer |
| pin_en | input | 2 | Full-pin enable per buffer |
| clr_full | input | 2 | Host clear of each buffer's full flag |
| clr_ovf | input | 2 | Host clear of each buffer's overflow flag |
| store_stb | output | 1 | One-cycle write strobe to message storage |
| store_sel | output | 1 | Target buffer of the store |
| hit_flt | output | $clog2(NF) | Index of the filter that accepted the frame |
| err_frame | output | 1 | Request to signal an error frame |
| full | output | 2 | Buffer full flags |
| ovf | output | 2 | Sticky overflow flags |
| full_n | output | 2 | Active-low buffer-full pins |

## Verification
The hardest state to reach is a rollover that lands in a full buffer 1. To get there, buffer 0 must first be filled through a buffer-0 filter and buffer 1 must be filled through rollover, all without a host clear in between. Only then can a third buffer-0 hit show that `ovf[1]` is set while `ovf[0]` stays clear. The directed sequences build this state step by step after the vector table. The table itself returns both buffers to empty between entries, so the masking, extension-bit and priority cases are each judged from a known starting state.

// File: rtl/can_rx_router.sv
module can_rx_router #(
  parameter int IW  = 29,
  parameter int XW  = 18,
  parameter int NF0 = 2,
  parameter int NF  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_valid,
  input  logic                  msg_ok,
  input  logic [IW-1:0]         msg_id,
  input  logic                  msg_ext,
  input  logic                  listen_only,
  input  logic                  rollover_en,
  input  logic [IW-1:0]         mask0,
  input  logic [IW-1:0]         mask1,
  input  logic [NF*IW-1:0]      flt_id,
  input  logic [NF-1:0]         flt_ext,
  input  logic [1:0]            pin_func,
  input  logic [1:0]            pin_en,
  input  logic [1:0]            clr_full,
  input  logic [1:0]            clr_ovf,
  output logic                  store_stb,
  output logic                  store_sel,
  output logic [$clog2(NF)-1:0] hit_flt,
  output logic                  err_frame,
  output logic [1:0]            full,
  output logic [1:0]            ovf,
  output logic [1:0]            full_n
);
  localparam int HW = $clog2(NF);
  localparam logic [IW-1:0] STD_CARE = {{(IW-XW){1'b1}}, {XW{1'b0}}};
  localparam logic [IW-1:0] EXT_CARE = STD_CARE | {{(IW-XW+2){1'b0}}, {(XW-2){1'b1}}};

  logic [IW-1:0] care;
  logic [NF-1:0] m;
  logic [HW-1:0] hit0, hit1, hsel;

  assign care = msg_ext ? EXT_CARE : STD_CARE;

  for (genvar i = 0; i < NF; i++) begin : g_flt
    localparam bit GRP0 = (i < NF0);
    assign m[i] = (msg_ext == flt_ext[i]) &&
                  ~|((msg_id ^ flt_id[i*IW +: IW]) & (GRP0 ? mask0 : mask1) & care);
  end

  always_comb begin
    hit0 = '0;
    for (int i = NF0-1; i >= 0; i--) if (m[i]) hit0 = HW'(i);
    hit1 = '0;
    for (int i = NF-1; i >= NF0; i--) if (m[i]) hit1 = HW'(i);
  end

  logic accept, a0, a1, roll, go0, go1, ov0, ov1;
  assign accept = msg_valid && (msg_ok || listen_only);
  assign a0     = accept && (listen_only || |m[NF0-1:0]);
  assign roll   = a0 && full[0] && rollover_en;
  assign a1     = roll || (accept && !a0 && |m[NF-1:NF0]);
  assign go0    = a0 && !full[0];
  assign go1    = a1 && !full[1];
  assign ov0    = a0 && full[0] && !rollover_en;
  assign ov1    = a1 && full[1];
  assign hsel   = listen_only ? '0 : (a0 ? hit0 : hit1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_stb <= 1'b0;
      store_sel <= 1'b0;
      hit_flt   <= '0;
      err_frame <= 1'b0;
      full      <= '0;
      ovf       <= '0;
    end else begin
      store_stb <= go0 | go1;
      store_sel <= go1;
      if (go0 | go1) hit_flt <= hsel;
      err_frame <= msg_valid && !msg_ok && !listen_only;
      full      <= {go1, go0} | (full & ~clr_full);
      ovf       <= {ov1, ov0} | (ovf & ~clr_ovf);
    end
  end

  assign full_n = ~(full & pin_func & pin_en);

  p_err_no_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> !store_stb);
  p_store0_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && !store_sel) |-> !$past(full[0]));
  p_store1_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && store_sel) |-> !$past(full[1]));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) |-> ($past(full[0]) && !$past(rollover_en)));
  p_listen_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> !$past(listen_only));
  p_pin_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n[0] |-> full[0]);
  p_hit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> (hit_flt < HW'(NF)));
endmodule

// File: tb/tb_can_rx_router.sv
module tb_can_rx_router;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 29;
  localparam int NF = 6;
  localparam int NV = 10;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_ok = 0, msg_ext = 0, listen_only = 0, rollover_en = 0;
  logic [IW-1:0] msg_id = '0;
  logic [IW-1:0] mask0 = 29'h1FFFFFFF, mask1 = 29'h1FFFFFF0;
  logic [NF*IW-1:0] flt_id;
  logic [NF-1:0] flt_ext = 6'b100100;
  logic [1:0] pin_func = 0, pin_en = 0, clr_full = 0, clr_ovf = 0;
  logic store_stb, store_sel, err_frame;
  logic [2:0] hit_flt;
  logic [1:0] full, ovf, full_n;
  int compared = 0, mismatched = 0;

  assign flt_id = {29'h10000000, 29'h0C000000, 29'h0C000000,
                   29'h00012340, 29'h08000000, 29'h04000000};

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_router dut (.*);

  // {id, ext, ok, exp_stb, exp_sel, exp_hit, exp_err}
  localparam logic [36:0] TBL [NV] = '{
    {29'h04000000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0},
    {29'h08000000, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0},
    {29'h04040000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
    {29'h04000000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
    {29'h00012345, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0},
    {29'h00022340, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0},
    {29'h0C000000, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0},
    {29'h0C040000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
    {29'h10000000, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 1'b0},
    {29'h04000000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [IW-1:0] id, logic ext, logic ok);
    @(negedge clk);
    msg_id = id; msg_ext = ext; msg_ok = ok; msg_valid = 1;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic clear(logic [1:0] f, logic [1:0] o);
    @(negedge clk);
    clr_full = f; clr_ovf = o;
    @(negedge clk);
    clr_full = 0; clr_ovf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 full", full, 0);
    check("R11 ovf", ovf, 0);
    check("R11 full_n", full_n, 2'b11);
    check("R11 store_stb", store_stb, 0);
    check("R11 err_frame", err_frame, 0);

    for (int v = 0; v < NV; v++) begin
      send(TBL[v][36:8], TBL[v][7], TBL[v][6]);
      check($sformatf("R2/R5/R6/R7 stb v%0d", v), store_stb, TBL[v][5]);
      check($sformatf("R1 err v%0d", v), err_frame, TBL[v][0]);
      if (TBL[v][5]) begin
        check($sformatf("R2/R5 sel v%0d", v), store_sel, TBL[v][4]);
        check($sformatf("R2/R5 hit v%0d", v), hit_flt, TBL[v][3:1]);
      end
      clear(2'b11, 2'b11);
    end
    @(negedge clk);
    check("R1 err one cycle", err_frame, 0);

    // R3: rollover, then rollover into full buffer 1
    rollover_en = 1;
    send(29'h04000000, 0, 1);
    check("R2 full0 set", full, 2'b01);
    send(29'h08000000, 0, 1);
    check("R3 roll stb", store_stb, 1);
    check("R3 roll sel", store_sel, 1);
    check("R3 roll hit", hit_flt, 1);
    send(29'h04000000, 0, 1);
    check("R3 no store when both full", store_stb, 0);
    check("R5 ovf1 from rollover", ovf, 2'b10);
    clear(2'b11, 2'b11);
    check("R10 flags cleared", {full, ovf}, 0);

    // R4: no rollover
    rollover_en = 0;
    send(29'h04000000, 0, 1);
    send(29'h08000000, 0, 1);
    check("R4 drop", store_stb, 0);
    check("R4 ovf0", ovf, 2'b01);
    clear(2'b00, 2'b01);
    check("R10 clr_ovf", ovf, 0);
    check("R10 full kept", full, 2'b01);

    // R5: buffer 1 full
    send(29'h0C000000, 0, 1);
    send(29'h0C000000, 0, 1);
    check("R5 drop full1", store_stb, 0);
    check("R5 ovf1", ovf, 2'b10);
    clear(2'b11, 2'b11);

    // R9: pin gating
    send(29'h04000000, 0, 1);
    pin_func = 2'b01; pin_en = 2'b00;
    @(negedge clk);
    check("R9 enable off", full_n, 2'b11);
    pin_en = 2'b01;
    @(negedge clk);
    check("R9 pin low", full_n, 2'b10);
    pin_func = 2'b00;
    @(negedge clk);
    check("R9 function off", full_n, 2'b11);
    pin_func = 2'b01;
    clear(2'b01, 2'b00);
    check("R10 pin released", full_n, 2'b11);

    // R10: store wins over simultaneous clear
    @(negedge clk);
    msg_id = 29'h04000000; msg_ext = 0; msg_ok = 1; msg_valid = 1; clr_full = 2'b01;
    @(negedge clk);
    msg_valid = 0; clr_full = 0;
    check("R10 store beats clear", full[0], 1);
    clear(2'b11, 2'b11);

    // R8: listen-only
    listen_only = 1;
    send(29'h1ABCDEF0, 1, 0);
    check("R8 stb", store_stb, 1);
    check("R8 sel", store_sel, 0);
    check("R8 hit", hit_flt, 0);
    check("R8 no err", err_frame, 0);
    send(29'h00000001, 0, 1);
    check("R8 full rule ovf0", ovf, 2'b01);
    listen_only = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule